// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between a set of peripheral interrupt lines and a 16-bit CPU. Each line sets a sticky pending flag. Software gives every source an enable bit and a 3-bit priority over a small register bus. Purely combinational logic picks the strongest eligible pending source. That source's vector number and level are captured into a readable status word one clock later.

The captured level is compared with the CPU's current 3-bit level. When it is strictly higher, the block raises a request and presents a vector address taken from either the primary or the alternate table. On acknowledge, the block pushes the CPU's old level onto a small internal stack and raises the level. The new level is the served source's level, or 7 when nesting is disabled. A return pulse pops the saved level back.

Top module: `vecIntController`

## Requirements
- R1: A source pulse sets that source's pending flag, which stays set until software writes 0 to it. A pulse in the same cycle as a software clear leaves the flag set. Source n occupies bit n%16 of flag word n/16, and the flag words sit at addresses 0x00 upward.
- R2: Enable words sit at 0x08 upward with the same bit packing as the flags. A pending source whose enable bit is 0 never wins arbitration.
- R3: A source with priority 0 never wins, and never raises a request.
- R4: Priority words sit at 0x10 upward. Source n uses bits 4*(n%4)+2 down to 4*(n%4) of word n/4, and the fourth bit of each nibble reads back 0. Flag, enable and priority words read back what was written.
- R5: Among eligible pending sources, the highest priority wins. On equal priority, the lowest source number wins.
- R6: The status word at 0x32 holds the winner's number in bits 6:0 and its level in bits 11:8, and reads 0 when nothing is eligible. It changes one clock after the flag change that causes it.
- R7: The CPU level at 0x31, bits 2:0, is writable and readable. irqReq is 1 exactly when the status level is strictly greater than the CPU level.
- R8: vecAddr equals 0x14 plus twice the status vector number, plus 0x100 when bit 0 of the control word at 0x30 is 1.
- R9: intAck while irqReq is high pushes the CPU level and sets the CPU level to the status level.
- R10: When bit 1 of the control word is 1, an accepted acknowledge sets the CPU level to 7.
- R11: An intRet pulse restores the most recently pushed level. With the stack empty, intRet changes nothing.
- R12: intAck while irqReq is low leaves the CPU level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcPulse | input | NUM_SRC | One-cycle request pulses, one per source |
| regAddr | input | 6 | Register word address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |
| intAck | input | 1 | CPU accepts the presented request |
| intRet | input | 1 | CPU returns from a handler |
| irqReq | output | 1 | Request to the CPU |
| vecAddr | output | 16 | Vector address of the current winner |

## Verification
The bench builds the block with NUM_SRC=16 and STACK_DEPTH=4. With that size, every source can be tried at every one of the eight priorities, in both vector tables. Every one of the 120 source pairs can also be raised together under a fixed priority pattern that includes ties and zero levels, with and without the lower source disabled. The small stack allows a full push, pop and empty-pop sequence, including the nesting-disable path.

// File: rtl/vecIntPkg.sv
package vecIntPkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam logic [ADDR_W-1:0] FLAG_BASE = 6'h00;
  localparam logic [ADDR_W-1:0] EN_BASE   = 6'h08;
  localparam logic [ADDR_W-1:0] PRI_BASE  = 6'h10;
  localparam logic [ADDR_W-1:0] PRI_END   = 6'h30;
  localparam logic [ADDR_W-1:0] CFG_ADDR  = 6'h30;
  localparam logic [ADDR_W-1:0] LVL_ADDR  = 6'h31;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 6'h32;

  typedef struct packed {
    logic       wrFlag;
    logic       wrEn;
    logic       wrPri;
    logic       wrCfg;
    logic [4:0] idx;
  } regStrobe_t;
endpackage

// File: rtl/intDatapath.sv
module intDatapath
  import vecIntPkg::*;
#(
  parameter int          NUM_SRC    = 64,
  parameter logic [15:0] VEC_BASE   = 16'h0014,
  parameter logic [15:0] ALT_OFFSET = 16'h0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcPulse,
  input  regStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  dpRdata,
  output logic [6:0]         statusVec,
  output logic [3:0]         statusLvl,
  output logic               statusValid,
  output logic               nstDis,
  output logic [15:0]        vecAddr
);
  localparam int PRI_W = 3;

  logic [NUM_SRC-1:0] flagQ, enQ;
  logic [PRI_W-1:0]   priQ [NUM_SRC];
  logic               altSel;
  logic [PRI_W-1:0]   winPri;
  logic [6:0]         winVec;
  logic [4:0]         priIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ  <= '0;
      enQ    <= '0;
      altSel <= 1'b0;
      nstDis <= 1'b0;
      for (int n = 0; n < NUM_SRC; n++) priQ[n] <= '0;
    end else begin
      for (int n = 0; n < NUM_SRC; n++) begin
        if (srcPulse[n])
          flagQ[n] <= 1'b1;
        else if (strobe.wrFlag && int'(strobe.idx) == n / 16)
          flagQ[n] <= regWdata[n % 16];
        if (strobe.wrEn && int'(strobe.idx) == n / 16)
          enQ[n] <= regWdata[n % 16];
        if (strobe.wrPri && int'(strobe.idx) == n / 4)
          priQ[n] <= regWdata[4*(n%4) +: PRI_W];
      end
      if (strobe.wrCfg) begin
        altSel <= regWdata[0];
        nstDis <= regWdata[1];
      end
    end
  end

  // Arbitration: strict greater-than keeps the lowest number on ties
  // and excludes priority 0.
  always_comb begin
    winPri = '0;
    winVec = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (flagQ[n] && enQ[n] && priQ[n] > winPri) begin
        winPri = priQ[n];
        winVec = 7'(n);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusVec   <= '0;
      statusLvl   <= '0;
      statusValid <= 1'b0;
    end else begin
      statusVec   <= winVec;
      statusLvl   <= {1'b0, winPri};
      statusValid <= (winPri != '0);
    end
  end

  assign vecAddr = VEC_BASE + 16'({statusVec, 1'b0}) + (altSel ? ALT_OFFSET : 16'h0000);

  assign priIdx = 5'(regAddr - PRI_BASE);

  always_comb begin
    dpRdata = '0;
    if (regAddr[5:3] == FLAG_BASE[5:3]) begin
      for (int n = 0; n < NUM_SRC; n++)
        if (n / 16 == int'(regAddr[2:0])) dpRdata[n % 16] = flagQ[n];
    end else if (regAddr[5:3] == EN_BASE[5:3]) begin
      for (int n = 0; n < NUM_SRC; n++)
        if (n / 16 == int'(regAddr[2:0])) dpRdata[n % 16] = enQ[n];
    end else if (regAddr >= PRI_BASE && regAddr < PRI_END) begin
      for (int n = 0; n < NUM_SRC; n++)
        if (n / 4 == int'(priIdx)) dpRdata[4*(n%4) +: PRI_W] = priQ[n];
    end else if (regAddr == CFG_ADDR) begin
      dpRdata = {14'b0, nstDis, altSel};
    end else if (regAddr == STAT_ADDR) begin
      dpRdata = {4'b0, statusLvl, 1'b0, statusVec};
    end
  end

  localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.wrFlag) |-> ((flagQ & $past(flagQ)) == $past(flagQ))); // R1
  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ((flagQ & $past(srcPulse)) == $past(srcPulse))); // R1
  AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> |($past(flagQ & enQ) & (ONE << statusVec))); // R2
  AST_STATUS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(|(flagQ & enQ)) |-> !statusValid); // R6
endmodule

// File: rtl/intControl.sv
module intControl
  import vecIntPkg::*;
#(
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [2:0]        lvlWdata,
  input  logic              intAck,
  input  logic              intRet,
  input  logic [3:0]        statusLvl,
  input  logic              nstDis,
  output regStrobe_t        strobe,
  output logic [2:0]        cpuLevel,
  output logic              irqReq
);
  localparam int PTR_W   = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int DEPTH_W = $clog2(STACK_DEPTH + 1);

  logic [2:0]         stackMem [STACK_DEPTH];
  logic [DEPTH_W-1:0] depth, topIdx;
  logic               ackTake, retTake, lvlWrite;

  always_comb begin
    strobe.wrFlag = regWe && regAddr[5:3] == FLAG_BASE[5:3];
    strobe.wrEn   = regWe && regAddr[5:3] == EN_BASE[5:3];
    strobe.wrPri  = regWe && regAddr >= PRI_BASE && regAddr < PRI_END;
    strobe.wrCfg  = regWe && regAddr == CFG_ADDR;
    strobe.idx    = (regAddr >= PRI_BASE) ? 5'(regAddr - PRI_BASE) : {2'b0, regAddr[2:0]};
  end

  assign irqReq   = {1'b0, cpuLevel} < statusLvl;
  assign ackTake  = intAck && irqReq;
  assign retTake  = intRet && !ackTake && depth != '0;
  assign lvlWrite = regWe && regAddr == LVL_ADDR;
  assign topIdx   = depth - 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuLevel <= '0;
      depth    <= '0;
    end else if (ackTake) begin
      if (depth < DEPTH_W'(STACK_DEPTH)) depth <= depth + 1'b1;
      cpuLevel <= nstDis ? 3'd7 : statusLvl[2:0];
    end else if (retTake) begin
      depth    <= topIdx;
      cpuLevel <= stackMem[topIdx[PTR_W-1:0]];
    end else if (lvlWrite) begin
      cpuLevel <= lvlWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (ackTake && depth < DEPTH_W'(STACK_DEPTH))
      stackMem[depth[PTR_W-1:0]] <= cpuLevel;
  end

  AST_ACK_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    $past(ackTake && !nstDis) |-> cpuLevel == $past(statusLvl[2:0])); // R9
  AST_NEST_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    $past(ackTake && nstDis) |-> cpuLevel == 3'd7); // R10
  AST_RET_POP: assert property (@(posedge clk) disable iff (!rstN)
    $past(retTake) |-> depth == $past(depth) - 1'b1); // R11
  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    $past(intAck && !irqReq && !intRet && !lvlWrite) |-> $stable(cpuLevel)); // R12
endmodule

// File: rtl/vecIntController.sv
module vecIntController
  import vecIntPkg::*;
#(
  parameter int          NUM_SRC     = 64,
  parameter int          STACK_DEPTH = 8,
  parameter logic [15:0] VEC_BASE    = 16'h0014,
  parameter logic [15:0] ALT_OFFSET  = 16'h0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcPulse,
  input  logic [5:0]         regAddr,
  input  logic               regWe,
  input  logic [15:0]        regWdata,
  output logic [15:0]        regRdata,
  input  logic               intAck,
  input  logic               intRet,
  output logic               irqReq,
  output logic [15:0]        vecAddr
);
  regStrobe_t  strobe;
  logic [15:0] dpRdata;
  logic [6:0]  statusVec;
  logic [3:0]  statusLvl;
  logic        statusValid, nstDis;
  logic [2:0]  cpuLevel;

  intControl #(.STACK_DEPTH(STACK_DEPTH)) uCtl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .lvlWdata(regWdata[2:0]), .intAck(intAck), .intRet(intRet),
    .statusLvl(statusLvl), .nstDis(nstDis), .strobe(strobe),
    .cpuLevel(cpuLevel), .irqReq(irqReq)
  );

  intDatapath #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE), .ALT_OFFSET(ALT_OFFSET)) uDp (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .strobe(strobe),
    .regAddr(regAddr), .regWdata(regWdata), .dpRdata(dpRdata),
    .statusVec(statusVec), .statusLvl(statusLvl), .statusValid(statusValid),
    .nstDis(nstDis), .vecAddr(vecAddr)
  );

  assign regRdata = (regAddr == LVL_ADDR) ? {13'b0, cpuLevel} : dpRdata;

  AST_REQ_VALID: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> statusValid && !vecAddr[0] && vecAddr >= VEC_BASE); // R8
endmodule

// File: tb/tb_vecIntController.sv
`timescale 1ns/1ps
module tb_vecIntController;
  localparam int NS = 16;
  localparam int SD = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcPulse = '0;
  logic [5:0]    regAddr = '0;
  logic          regWe = 1'b0;
  logic [15:0]   regWdata = '0;
  logic [15:0]   regRdata;
  logic          intAck = 1'b0, intRet = 1'b0;
  logic          irqReq;
  logic [15:0]   vecAddr;
  int nTests = 0, nFail = 0;

  vecIntController #(.NUM_SRC(NS), .STACK_DEPTH(SD)) dut (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .regAddr(regAddr),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .intAck(intAck), .intRet(intRet), .irqReq(irqReq), .vecAddr(vecAddr)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); regAddr = a; regWe = 1'b1; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output int d);
    regAddr = a; #1; d = int'(regRdata);
  endtask

  task automatic pulse(input int s);
    @(negedge clk); srcPulse = NS'(1) << s;
    @(negedge clk); srcPulse = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk); intRet = 1'b1;
    @(negedge clk); intRet = 1'b0;
  endtask

  function automatic int patPri(input int s);
    return (s * 3 + 1) % 8;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int v, ex, wpri, wsrc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    // reset state
    rd(6'h32, v); chk("R6 reset status", v, 0);
    chk("R7 reset irq", int'(irqReq), 0);
    rd(6'h31, v); chk("R7 reset level", v, 0);
    rd(6'h00, v); chk("R1 reset flags", v, 0);

    // R4 readback
    wr(6'h08, 16'hA5C3); rd(6'h08, v); chk("R4 enable readback", v, 16'hA5C3);
    wr(6'h11, 16'hF9AB); rd(6'h11, v); chk("R4 priority readback", v, 16'h7123);
    wr(6'h00, 16'h0F0F); rd(6'h00, v); chk("R4 flag readback", v, 16'h0F0F);
    wr(6'h00, 16'h0000); rd(6'h00, v); chk("R1 software clear", v, 0);

    // R1 hardware set beats software clear
    wr(6'h00, 16'h0004);
    @(negedge clk); srcPulse = NS'(1) << 2; regAddr = 6'h00; regWe = 1'b1; regWdata = 16'h0;
    @(negedge clk); srcPulse = '0; regWe = 1'b0;
    rd(6'h00, v); chk("R1 set wins over clear", v, 16'h0004);
    wr(6'h00, 16'h0000);
    pulse(5); repeat (4) step();
    rd(6'h00, v); chk("R1 flag sticky", v, 16'h0020);
    wr(6'h00, 16'h0000);

    // R6 timing: status lags flag by one clock
    wr(6'h08, 16'hFFFF);
    for (int w = 0; w < 4; w++) wr(6'h10 + 6'(w), 16'h0);
    wr(6'h10, 16'h0500);            // source 2 at level 5
    step();
    rd(6'h32, v); chk("R6 idle before pulse", v, 0);
    pulse(2);
    rd(6'h32, v); chk("R6 status not yet updated", v, 0);
    step();
    rd(6'h32, v); chk("R6 status one clock later", v, (5 << 8) | 2);
    wr(6'h00, 16'h0000);

    // single source x priority x table sweep
    for (int s = 0; s < NS; s++) begin
      for (int p = 0; p < 8; p++) begin
        wr(6'h00, 16'h0);
        for (int w = 0; w < 4; w++)
          wr(6'h10 + 6'(w), (w == s / 4) ? 16'(p << (4 * (s % 4))) : 16'h0);
        wr(6'h30, 16'(s % 2));
        pulse(s); step();
        rd(6'h32, v);
        chk("R3 R5 R6 single status", v, (p > 0) ? ((p << 8) | s) : 0);
        chk("R3 R7 single irq", int'(irqReq), (p > 0) ? 1 : 0);
        if (p > 0)
          chk("R8 vector address", int'(vecAddr), 16'h14 + 2 * s + ((s % 2) ? 16'h100 : 0));
      end
    end
    wr(6'h30, 16'h0);

    // pair sweep with a fixed priority pattern
    for (int w = 0; w < 4; w++)
      wr(6'h10 + 6'(w), 16'((patPri(4*w+3) << 12) | (patPri(4*w+2) << 8) |
                            (patPri(4*w+1) << 4) | patPri(4*w)));
    for (int i = 0; i < NS; i++) begin
      for (int j = i + 1; j < NS; j++) begin
        wr(6'h08, 16'hFFFF);
        wr(6'h00, 16'((1 << i) | (1 << j)));
        step();
        wpri = patPri(i); wsrc = i;
        if (patPri(j) > wpri) begin wpri = patPri(j); wsrc = j; end
        ex = (wpri > 0) ? ((wpri << 8) | wsrc) : 0;
        rd(6'h32, v); chk("R5 pair winner", v, ex);
        wr(6'h08, 16'(~(1 << i)));
        step();
        ex = (patPri(j) > 0) ? ((patPri(j) << 8) | j) : 0;
        rd(6'h32, v); chk("R2 disabled source skipped", v, ex);
      end
    end
    wr(6'h08, 16'hFFFF);
    wr(6'h00, 16'h0);

    // R7 level comparison sweep
    for (int w = 0; w < 4; w++) wr(6'h10 + 6'(w), 16'h0);
    wr(6'h10, 16'h4000);            // source 3 at level 4
    pulse(3); step();
    for (int l = 0; l < 8; l++) begin
      wr(6'h31, 16'(l));
      rd(6'h31, v); chk("R7 level readback", v, l);
      chk("R7 strict compare", int'(irqReq), (4 > l) ? 1 : 0);
    end
    wr(6'h31, 16'h0);
    wr(6'h00, 16'h0);

    // acknowledge, nesting and return
    wr(6'h10, 16'h0030);            // source 1 at level 3
    wr(6'h12, 16'h0060);            // source 9 at level 6
    pulse(1); step();
    chk("R7 irq for level 3", int'(irqReq), 1);
    ack();
    rd(6'h31, v); chk("R9 level raised on ack", v, 3);
    chk("R9 irq drops", int'(irqReq), 0);
    pulse(9); step();
    rd(6'h32, v); chk("R5 higher source status", v, (6 << 8) | 9);
    chk("R7 nested irq", int'(irqReq), 1);
    ack();
    rd(6'h31, v); chk("R9 nested level", v, 6);
    ack();
    rd(6'h31, v); chk("R12 ack without request", v, 6);
    ret();
    rd(6'h31, v); chk("R11 first pop", v, 3);
    ret();
    rd(6'h31, v); chk("R11 second pop", v, 0);
    ret();
    rd(6'h31, v); chk("R11 empty pop", v, 0);
    wr(6'h30, 16'h0002);
    chk("R10 irq pending", int'(irqReq), 1);
    ack();
    rd(6'h31, v); chk("R10 level forced to 7", v, 7);
    chk("R10 no preemption", int'(irqReq), 0);
    ret();
    rd(6'h31, v); chk("R11 pop after nest-disable", v, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule